// File: doc/BRIEF.md
# Averaging ADC Conversion Sequencer

This block is the digital controller that sits in front of a successive-approximation converter. Software programs it through five small registers. Writing the channel register picks an input channel and starts a conversion. The block counts the conversion in ticks of a conversion clock derived from the bus clock. It takes one or more samples from the converter data input and averages them. It then masks the average to the chosen resolution, stores it and raises a completion flag. When interrupts are enabled, the flag also drives an interrupt.

The analog converter is modelled by the `sample_in` port. That port is captured on the last conversion-clock tick of every base conversion. A continuous mode starts the next conversion on the same channel at once. A stop code halts conversions. A protection option keeps an unread result from being replaced. The reference, power and calibration bits are stored and read back only.

Top module: `adc_seq_top`

## Requirements
- R1: A conversion lasts 6 + N*(25 + L) conversion-clock ticks. L comes from config bit 6 (long) and config bits [8:7] (sel). With long clear, L = 3, 5, 7, 9 for sel 0..3. With long set, L = 13, 17, 21, 25.
- R2: N is 1 when general-control bit 0 (average enable) is clear. When that bit is set, config bits [10:9] set N: codes 0, 1, 2, 3 give 4, 8, 16, 32.
- R3: The stored value is the sum of the N captured samples shifted right by log2(N), truncated. Each sample is `sample_in` as present at the clock edge of the last tick of each 25+L window.
- R4: Config bits [5:4] select the resolution. Code 0 masks the result to 0xFF, code 1 to 0x3FF, and code 2 or 3 to 0xFFF.
- R5: Registers sit at word addresses 0 channel, 1 config, 2 general control, 3 status, 4 result. The channel register holds the channel in bits [4:0] and interrupt enable in bit 7. Writing a channel code other than 0x1F starts a conversion and drives that code on `chan_sel`. Writing 0x1F stops conversions and clears `busy`.
- R6: Status bit 0 is the completion flag, set when a result is stored. Status bit 1 mirrors `busy`. `irq` equals the flag while channel bit 7 is set and is 0 otherwise.
- R7: A read of the result register clears the completion flag.
- R8: With general-control bit 1 (continuous) set, a new conversion on the same channel begins at once when one completes, so completions repeat every conversion time. With the bit clear, `busy` falls at completion.
- R9: Config bits [1:0] divide the bus clock by 1, 2, 4 or 8 to form the conversion clock. If config bits [3:2] equal 1 and the divider code is 3, the division is 16. One conversion therefore takes (conversion ticks) x (division) bus cycles from the write.
- R10: Config bit 11 enables overwrite. When it is clear and the flag is still set, a new result is discarded and the old one is kept.
- R11: Writing the channel register during a conversion aborts that conversion. The new one is timed from the new write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has side effect on result register) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | REG_W (16) | Write data |
| reg_rdata | output | REG_W (16) | Read data, combinational from address |
| sample_in | input | DATA_W (12) | Converter output data |
| chan_sel | output | CHAN_W (5) | Selected input channel for the analog multiplexer |
| busy | output | 1 | A conversion sequence is in progress |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong cycle or sample counter shows up as a completion edge that arrives early or late. Because the bench measures every conversion to the bus cycle, it sees that at the first completion. A wrong accumulator or shift leaves a wrong value in the result register on the first read. Each stimulus drives a different `sample_in` value on every cycle, so a capture one cycle off is visible as well. A wrong flag or activity state shows up at once on `irq`, `busy` or status bit 0. This includes a discarded result overwriting the old one and a stop that does not stop.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam logic [2:0] RA_CHAN = 3'd0;
    localparam logic [2:0] RA_CFG  = 3'd1;
    localparam logic [2:0] RA_GCTL = 3'd2;
    localparam logic [2:0] RA_STAT = 3'd3;
    localparam logic [2:0] RA_RES  = 3'd4;

    // config register field positions
    localparam int CF_DIV  = 0;  // [1:0]
    localparam int CF_SRC  = 2;  // [3:2]
    localparam int CF_RES  = 4;  // [5:4]
    localparam int CF_LONG = 6;
    localparam int CF_STS  = 7;  // [8:7]
    localparam int CF_AVS  = 9;  // [10:9]
    localparam int CF_OVW  = 11;

    localparam int GC_AVEN = 0;
    localparam int GC_CONT = 1;

    localparam int MAX_SHIFT = 5;

    function automatic logic [5:0] lst_cycles(input logic long_b, input logic [1:0] sel);
        if (long_b) return 6'd13 + {2'b00, sel, 2'b00};
        else        return 6'd3  + {3'b000, sel, 1'b0};
    endfunction

    function automatic logic [2:0] avg_shift(input logic en, input logic [1:0] sel);
        if (en) return 3'd2 + {1'b0, sel};
        else    return 3'd0;
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int DIV_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] div_code,
    input  logic [1:0] src_code,
    output logic       tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        if (src_code == 2'd1 && div_code == 2'd3)
            limit = DIV_W'(15);
        else
            limit = DIV_W'((1 << div_code) - 1);

        tick  = run && !restart && (cnt_q >= limit);
        cnt_d = cnt_q;
        if (!run || restart || cnt_q >= limit)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int ADDER_CYC = 6,
    parameter int BASE_CYC  = 25,
    parameter int CYC_W     = 6,
    parameter int SMP_W     = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       start,
    input  logic       tick,
    input  logic [5:0] lst,
    input  logic [2:0] shift,
    output logic       smp_strobe,
    output logic       first_smp,
    output logic       done
);
    typedef struct packed {
        logic             in_adder;
        logic [CYC_W-1:0] cyc;
        logic [SMP_W-1:0] smp;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [CYC_W-1:0] per_last;
    logic [SMP_W-1:0] smp_last;

    localparam tmr_t TMR_IDLE = '{in_adder: 1'b1, cyc: '0, smp: '0};

    always_comb begin
        per_last   = CYC_W'(BASE_CYC) + CYC_W'(lst) - 1'b1;
        smp_last   = SMP_W'((1 << shift) - 1);
        tmr_d      = tmr_q;
        smp_strobe = 1'b0;
        done       = 1'b0;
        first_smp  = (tmr_q.smp == '0);

        if (start || !run) begin
            tmr_d = TMR_IDLE;
        end else if (tick) begin
            if (tmr_q.in_adder) begin
                if (tmr_q.cyc >= CYC_W'(ADDER_CYC - 1)) begin
                    tmr_d.in_adder = 1'b0;
                    tmr_d.cyc      = '0;
                end else begin
                    tmr_d.cyc = tmr_q.cyc + 1'b1;
                end
            end else if (tmr_q.cyc >= per_last) begin
                smp_strobe = 1'b1;
                tmr_d.cyc  = '0;
                if (tmr_q.smp >= smp_last) begin
                    done  = 1'b1;
                    tmr_d = TMR_IDLE;
                end else begin
                    tmr_d.smp = tmr_q.smp + 1'b1;
                end
            end else begin
                tmr_d.cyc = tmr_q.cyc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= TMR_IDLE;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/adc_avg.sv
module adc_avg #(
    parameter int DATA_W    = 12,
    parameter int MAX_SHIFT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_strobe,
    input  logic              first_smp,
    input  logic [DATA_W-1:0] sample,
    input  logic [2:0]        shift,
    input  logic [1:0]        res_code,
    output logic [DATA_W-1:0] value
);
    localparam int ACC_W = DATA_W + MAX_SHIFT;

    logic [ACC_W-1:0]  acc_d, acc_q;
    logic [ACC_W-1:0]  sum_now;
    logic [ACC_W-1:0]  avg_full;
    logic [DATA_W-1:0] mask;

    always_comb begin
        sum_now  = (first_smp ? '0 : acc_q) + ACC_W'(sample);
        avg_full = sum_now >> shift;
        case (res_code)
            2'd0:    mask = DATA_W'((1 << (DATA_W - 4)) - 1);
            2'd1:    mask = DATA_W'((1 << (DATA_W - 2)) - 1);
            default: mask = '1;
        endcase
        value = avg_full[DATA_W-1:0] & mask;
        acc_d = smp_strobe ? sum_now : acc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int CHAN_W    = 5,
    parameter int REG_W     = 16,
    parameter int ADDER_CYC = 6,
    parameter int BASE_CYC  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [DATA_W-1:0] sample_in,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              busy,
    output logic              irq
);
    localparam int CYC_W = $clog2(BASE_CYC + 26);
    localparam int SMP_W = MAX_SHIFT + 1;
    localparam int GC_W  = 8;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              ien;
        logic [REG_W-1:0]  cfg;
        logic [GC_W-1:0]   gctl;
        logic              active;
        logic              flag;
        logic [DATA_W-1:0] result;
    } seq_t;

    seq_t st_d, st_q;

    logic              chan_wr, stop_code;
    logic              cdiv_tick, smp_strobe, first_smp, conv_done;
    logic [5:0]        lst;
    logic [2:0]        shift;
    logic [DATA_W-1:0] avg_value;
    logic              ovw_en, cont_en, flag_w;
    logic [1:0]        div_code;
    logic [DATA_W-1:0] result_w;

    assign chan_wr   = reg_wr && (reg_addr == RA_CHAN);
    assign stop_code = (reg_wdata[CHAN_W-1:0] == '1);
    assign lst       = lst_cycles(st_q.cfg[CF_LONG], st_q.cfg[CF_STS +: 2]);
    assign shift     = avg_shift(st_q.gctl[GC_AVEN], st_q.cfg[CF_AVS +: 2]);
    assign ovw_en    = st_q.cfg[CF_OVW];
    assign cont_en   = st_q.gctl[GC_CONT];
    assign div_code  = st_q.cfg[CF_DIV +: 2];
    assign flag_w    = st_q.flag;
    assign result_w  = st_q.result;

    adc_clk_div #(.DIV_W(4)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st_q.active),
        .restart  (chan_wr),
        .div_code (div_code),
        .src_code (st_q.cfg[CF_SRC +: 2]),
        .tick     (cdiv_tick)
    );

    adc_conv_timer #(
        .ADDER_CYC (ADDER_CYC),
        .BASE_CYC  (BASE_CYC),
        .CYC_W     (CYC_W),
        .SMP_W     (SMP_W)
    ) i_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (st_q.active),
        .start      (chan_wr),
        .tick       (cdiv_tick),
        .lst        (lst),
        .shift      (shift),
        .smp_strobe (smp_strobe),
        .first_smp  (first_smp),
        .done       (conv_done)
    );

    adc_avg #(.DATA_W(DATA_W), .MAX_SHIFT(MAX_SHIFT)) i_avg (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_strobe (smp_strobe),
        .first_smp  (first_smp),
        .sample     (sample_in),
        .shift      (shift),
        .res_code   (st_q.cfg[CF_RES +: 2]),
        .value      (avg_value)
    );

    always_comb begin
        st_d = st_q;

        if (chan_wr) begin
            st_d.chan   = reg_wdata[CHAN_W-1:0];
            st_d.ien    = reg_wdata[7];
            st_d.active = !stop_code;
        end else if (conv_done && !cont_en) begin
            st_d.active = 1'b0;
        end

        if (reg_wr && reg_addr == RA_CFG)  st_d.cfg  = reg_wdata;
        if (reg_wr && reg_addr == RA_GCTL) st_d.gctl = reg_wdata[GC_W-1:0];

        if (reg_rd && reg_addr == RA_RES) st_d.flag = 1'b0;

        if (conv_done && (ovw_en || !st_q.flag)) begin
            st_d.result = avg_value;
            st_d.flag   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CHAN: begin
                reg_rdata[CHAN_W-1:0] = st_q.chan;
                reg_rdata[7]          = st_q.ien;
            end
            RA_CFG:  reg_rdata = st_q.cfg;
            RA_GCTL: reg_rdata[GC_W-1:0] = st_q.gctl;
            RA_STAT: begin
                reg_rdata[0] = st_q.flag;
                reg_rdata[1] = st_q.active;
            end
            RA_RES:  reg_rdata[DATA_W-1:0] = st_q.result;
            default: reg_rdata = '0;
        endcase
    end

    assign chan_sel = st_q.chan;
    assign busy     = st_q.active;
    assign irq      = st_q.flag && st_q.ien;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int DATA_W = 12,
    parameter int CHAN_W = 5,
    parameter int REG_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [CHAN_W-1:0] chan_sel,
    input logic              busy,
    input logic              conv_done,
    input logic              cdiv_tick,
    input logic [1:0]        div_code,
    input logic              ovw_en,
    input logic              cont_en,
    input logic              flag,
    input logic [DATA_W-1:0] result
);
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && reg_wdata[CHAN_W-1:0] == '1) |=> !busy); // R5

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && reg_wdata[CHAN_W-1:0] != '1)
        |=> (busy && chan_sel == $past(reg_wdata[CHAN_W-1:0]))); // R5

    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> flag); // R6

    AST_KEEP_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !ovw_en && flag) |=> $stable(result)); // R10

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !cont_en && !(reg_wr && reg_addr == 3'd0)) |=> !busy); // R8

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cdiv_tick && div_code != 2'd0) |=> !cdiv_tick); // R9
endmodule

bind adc_seq_top adc_seq_chk #(
    .DATA_W (DATA_W),
    .CHAN_W (CHAN_W),
    .REG_W  (REG_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .chan_sel  (chan_sel),
    .busy      (busy),
    .conv_done (conv_done),
    .cdiv_tick (cdiv_tick),
    .div_code  (div_code),
    .ovw_en    (ovw_en),
    .cont_en   (cont_en),
    .flag      (flag_w),
    .result    (result_w)
);

// File: tb/test_adc_seq_top.sv
module test_adc_seq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [11:0] sample_in = '0;
    logic [4:0]  chan_sel;
    logic        busy;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    adc_seq_top i_adc_seq_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sample_in(sample_in), .chan_sel(chan_sel), .busy(busy), .irq(irq)
    );

    // {div,src,res,long,sel,aven,avs,seed}
    localparam int NV = 7;
    localparam logic [23:0] VEC [NV] = '{
        {2'd0, 2'd0, 2'd2, 1'b0, 2'd0, 1'b0, 2'd0, 12'h123},
        {2'd1, 2'd0, 2'd1, 1'b0, 2'd3, 1'b1, 2'd0, 12'h456},
        {2'd2, 2'd0, 2'd0, 1'b1, 2'd1, 1'b1, 2'd1, 12'h789},
        {2'd3, 2'd1, 2'd2, 1'b1, 2'd3, 1'b0, 2'd0, 12'hABC},
        {2'd0, 2'd0, 2'd2, 1'b1, 2'd2, 1'b1, 2'd3, 12'hFFF},
        {2'd3, 2'd0, 2'd2, 1'b0, 2'd2, 1'b1, 2'd2, 12'h010},
        {2'd1, 2'd2, 2'd2, 1'b1, 2'd0, 1'b1, 2'd0, 12'h3C5}
    };

    function automatic logic [11:0] gsmp(input int seed, input int j);
        int t;
        t = seed + j * 97;
        return t[11:0];
    endfunction

    function automatic int f_div(input logic [23:0] v);
        if (v[21:20] == 2'd1 && v[23:22] == 2'd3) return 16;
        return 1 << v[23:22];
    endfunction
    function automatic int f_lst(input logic [23:0] v);
        return v[17] ? 13 + 4 * v[16:15] : 3 + 2 * v[16:15];
    endfunction
    function automatic int f_sh(input logic [23:0] v);
        return v[14] ? 2 + v[13:12] : 0;
    endfunction
    function automatic int f_lat(input logic [23:0] v);
        return (6 + (1 << f_sh(v)) * (25 + f_lst(v))) * f_div(v);
    endfunction
    function automatic int f_val(input logic [23:0] v);
        int sum, t, m;
        sum = 0;
        for (int k = 0; k < (1 << f_sh(v)); k++) begin
            t = (6 + (k + 1) * (25 + f_lst(v))) * f_div(v);
            sum += gsmp(int'(v[11:0]), t - 1);
        end
        m = (v[19:18] == 2'd0) ? 8'hFF : (v[19:18] == 2'd1) ? 10'h3FF : 12'hFFF;
        return (sum >> f_sh(v)) & m;
    endfunction
    function automatic logic [15:0] mk_cfg(input logic [23:0] v, input logic ovw);
        logic [15:0] c;
        c = '0;
        c[1:0] = v[23:22]; c[3:2] = v[21:20]; c[5:4] = v[19:18];
        c[6] = v[17]; c[8:7] = v[16:15]; c[10:9] = v[13:12]; c[11] = ovw;
        return c;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // start a conversion, drive per-cycle samples, return cycles to irq
    task automatic conv(input logic [4:0] ch, input logic ien, input int seed,
                        input int limit, input bit stop_irq, output int lat);
        wr(3'd0, {8'h00, ien, 2'b00, ch});
        sample_in = gsmp(seed, 0);
        lat = -1;
        for (int j = 1; j <= limit; j++) begin
            @(negedge clk);
            if (stop_irq && irq) begin
                lat = j;
                break;
            end
            sample_in = gsmp(seed, j);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog (all requirements) actual=hang expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        int lat;
        logic [23:0] v1;
        v1 = VEC[0];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        check("R6 irq after reset", int'(irq), 0);
        check("R8 busy after reset", int'(busy), 0);
        rd(3'd3, r); check("R6 status after reset", int'(r), 0);
        rd(3'd4, r); check("R3 result after reset", int'(r), 0);

        // vector table: timing, averaging, mask, divider
        for (int i = 0; i < NV; i++) begin
            wr(3'd1, mk_cfg(VEC[i], 1'b1));
            wr(3'd2, {15'd0, VEC[i][14]});
            conv(5'(i + 3), 1'b1, int'(VEC[i][11:0]), 20000, 1'b1, lat);
            check($sformatf("R1 R2 R9 latency vec%0d", i), lat, f_lat(VEC[i]));
            check($sformatf("R5 chan_sel vec%0d", i), int'(chan_sel), i + 3);
            rd(3'd4, r);
            check($sformatf("R3 R4 result vec%0d", i), int'(r), f_val(VEC[i]));
            check($sformatf("R8 busy low after one-shot vec%0d", i), int'(busy), 0);
        end

        // R7: flag set, read result clears it
        wr(3'd1, mk_cfg(v1, 1'b1));
        wr(3'd2, 16'd0);
        conv(5'd2, 1'b1, 77, 200, 1'b1, lat);
        rd(3'd3, r); check("R6 status flag set", int'(r[0]), 1);
        check("R6 irq with enable", int'(irq), 1);
        rd(3'd4, r);
        rd(3'd3, r); check("R7 flag cleared by result read", int'(r[0]), 0);
        check("R7 irq cleared", int'(irq), 0);

        // R6: interrupt enable off
        conv(5'd2, 1'b0, 77, f_lat(v1) + 3, 1'b0, lat);
        check("R6 irq masked", int'(irq), 0);
        rd(3'd3, r); check("R6 flag set while masked", int'(r[0]), 1);
        rd(3'd4, r);

        // R10: overwrite disabled keeps old result
        wr(3'd1, mk_cfg(v1, 1'b0));
        conv(5'd1, 1'b1, 300, 200, 1'b1, lat);
        conv(5'd1, 1'b1, 900, f_lat(v1) + 3, 1'b0, lat);
        rd(3'd4, r);
        check("R10 old result kept", int'(r), int'(gsmp(300, f_lat(v1) - 1)));

        // R10: overwrite enabled replaces result
        wr(3'd1, mk_cfg(v1, 1'b1));
        conv(5'd1, 1'b1, 300, 200, 1'b1, lat);
        conv(5'd1, 1'b1, 900, f_lat(v1) + 3, 1'b0, lat);
        rd(3'd4, r);
        check("R10 new result replaces", int'(r), int'(gsmp(900, f_lat(v1) - 1)));

        // R11: rewrite during conversion aborts and restarts timing
        conv(5'd4, 1'b1, 5, 15, 1'b0, lat);
        conv(5'd6, 1'b1, 1234, 200, 1'b1, lat);
        check("R11 restart latency", lat, f_lat(v1));
        check("R11 new channel", int'(chan_sel), 6);
        rd(3'd4, r);
        check("R11 result from restart", int'(r), int'(gsmp(1234, f_lat(v1) - 1)));

        // R5: stop code halts conversion
        conv(5'd7, 1'b1, 5, 10, 1'b0, lat);
        wr(3'd0, 16'h009F);
        check("R5 busy cleared by stop", int'(busy), 0);
        repeat (60) @(negedge clk);
        rd(3'd3, r); check("R5 no completion after stop", int'(r[0]), 0);

        // R8: continuous conversion repeats
        wr(3'd2, 16'h0002);
        conv(5'd8, 1'b1, 50, 200, 1'b1, lat);
        check("R8 first continuous latency", lat, f_lat(v1));
        rd(3'd4, r);
        lat = -1;
        for (int j = 3; j <= 200; j++) begin
            @(negedge clk);
            if (irq) begin
                lat = j;
                break;
            end
        end
        check("R8 repeat period", lat, f_lat(v1));
        check("R8 still busy", int'(busy), 1);
        wr(3'd0, 16'h001F);
        wr(3'd2, 16'h0000);
        check("R8 stopped", int'(busy), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule